// File: doc/BRIEF.md
# One-Level Section Address Translator

This block turns a 32-bit virtual address into a physical address by consulting a one-level table of section descriptors held in memory. A requester presents an address on a valid/ready channel, along with an enable and the table base. When translation is enabled, the block computes where the descriptor lives, issues one word read on its memory port and waits as long as needed for the returned word. It then decodes the two type bits of that word.

A section descriptor yields a physical address built from the descriptor's top twelve bits and the low twenty bits of the virtual address, so each entry maps 1 MB. The response also carries the descriptor's domain, access and memory-type attributes. Any other type code produces a fault response with a zero address. When translation is disabled, the address passes straight through and no read is issued. Only one request is in flight at a time.

Top module: `section_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd` is 0.
- R2: An enabled translation raises `mem_rd` for exactly one cycle. While it is high, `mem_addr` equals `tbl_base + 4 * req_vaddr[31:20]`.
- R3: A returned word with bits [1:0] = 2'b10 gives `rsp_fault` = 0 and `rsp_paddr` = {word[31:20], vaddr[19:0]}.
- R4: For a section, the attributes are taken from fixed bit positions: `rsp_buf` from bit 2, `rsp_cache` from bit 3, `rsp_domain` from bits [8:5], `rsp_ap` from bits [11:10] and `rsp_apx` from bit 15.
- R5: A returned word with bits [1:0] equal to 2'b00, 2'b01 or 2'b11 gives `rsp_fault` = 1, with `rsp_paddr` and every attribute output at zero.
- R6: When `xlate_en` is 0 at acceptance, `rsp_paddr` equals `req_vaddr`, `rsp_fault` and all attributes are 0, and `mem_rd` never rises for that request.
- R7: Once `rsp_valid` is high, it stays high with all response fields stable until `rsp_ready` is seen. `req_ready` stays low from acceptance until the response is taken.
- R8: The descriptor may return any number of cycles (one or more) after the strobe. `mem_rdata` is ignored while `mem_rvalid` is low.
- R9: `xlate_en`, `tbl_base` and `req_vaddr` are sampled only at acceptance. Changing them afterwards has no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| xlate_en | input | 1 | 1: translate, 0: pass through |
| tbl_base | input | 32 | Byte address of the descriptor table |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation fault |
| rsp_domain | output | 4 | Domain number of the section |
| rsp_ap | output | 2 | Access permission bits |
| rsp_apx | output | 1 | Extended access permission bit |
| rsp_cache | output | 1 | Cacheable |
| rsp_buf | output | 1 | Bufferable |
| mem_rd | output | 1 | One-cycle descriptor read strobe |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rvalid | input | 1 | Descriptor word valid |
| mem_rdata | input | 32 | Descriptor word |

## Verification
A state machine stuck in the wait state shows as a response that never arrives, and the per-request timeout catches it within a few dozen cycles. A machine that leaves the wait state early latches whatever junk sits on the read data bus. That junk shows in the very next response as a wrong address or a wrong fault flag. Wrong index arithmetic or stale base sampling shows at the strobe cycle itself as a mismatched `mem_addr`. A dropped or repeated strobe shows in the strobe count per request.

// File: rtl/section_xlate.sv
module section_xlate #(
  parameter int IDX_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        xlate_en,
  input  logic [31:0] tbl_base,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic [3:0]  rsp_domain,
  output logic [1:0]  rsp_ap,
  output logic        rsp_apx,
  output logic        rsp_cache,
  output logic        rsp_buf,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int OFF_W = 32 - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} st_t;
  st_t st;

  logic [OFF_W-1:0] off_q;
  logic [31:0]      addr_q, paddr_q;
  logic             fault_q, apx_q, c_q, b_q;
  logic [3:0]       dom_q;
  logic [1:0]       ap_q;

  logic is_sect;
  assign is_sect = mem_rdata[1:0] == 2'b10;

  logic unused_bits;
  assign unused_bits = ^{mem_rdata[OFF_W-1:16], mem_rdata[14:12], mem_rdata[9], mem_rdata[4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      off_q   <= '0;
      addr_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      dom_q   <= '0;
      ap_q    <= '0;
      apx_q   <= 1'b0;
      c_q     <= 1'b0;
      b_q     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          off_q <= req_vaddr[OFF_W-1:0];
          if (xlate_en) begin
            addr_q <= tbl_base + {{(30-IDX_W){1'b0}}, req_vaddr[31:OFF_W], 2'b00};
            st     <= S_ISSUE;
          end else begin
            paddr_q <= req_vaddr;
            fault_q <= 1'b0;
            dom_q   <= '0;
            ap_q    <= '0;
            apx_q   <= 1'b0;
            c_q     <= 1'b0;
            b_q     <= 1'b0;
            st      <= S_RESP;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          fault_q <= !is_sect;
          paddr_q <= is_sect ? {mem_rdata[31:OFF_W], off_q} : '0;
          dom_q   <= is_sect ? mem_rdata[8:5] : '0;
          ap_q    <= is_sect ? mem_rdata[11:10] : '0;
          apx_q   <= is_sect & mem_rdata[15];
          c_q     <= is_sect & mem_rdata[3];
          b_q     <= is_sect & mem_rdata[2];
          st      <= S_RESP;
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = st == S_IDLE;
  assign rsp_valid  = st == S_RESP;
  assign mem_rd     = st == S_ISSUE;
  assign mem_addr   = addr_q;
  assign rsp_paddr  = paddr_q;
  assign rsp_fault  = fault_q;
  assign rsp_domain = dom_q;
  assign rsp_ap     = ap_q;
  assign rsp_apx    = apx_q;
  assign rsp_cache  = c_q;
  assign rsp_buf    = b_q;
endmodule

// File: rtl/section_xlate_chk.sv
module section_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_paddr,
  input logic        rsp_fault,
  input logic [3:0]  rsp_domain,
  input logic        mem_rd
);
  a_r7_hold_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_domain));
  a_r7_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  a_r2_strobe_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !req_ready && !rsp_valid);
  a_r5_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == 32'h0 && rsp_domain == 4'h0);
endmodule

bind section_xlate section_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .rsp_domain(rsp_domain), .mem_rd(mem_rd)
);

// File: tb/section_xlate_bench.sv
`timescale 1ns/1ps
module section_xlate_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, xlate_en = 0, rsp_ready = 0, mem_rvalid = 0;
  logic [31:0] req_vaddr = 0, tbl_base = 0, mem_rdata = 0;
  logic req_ready, rsp_valid, rsp_fault, rsp_apx, rsp_cache, rsp_buf, mem_rd;
  logic [31:0] rsp_paddr, mem_addr;
  logic [3:0] rsp_domain;
  logic [1:0] rsp_ap;

  always #4 clk = ~clk;

  section_xlate u_section_xlate (.*);

  int checks = 0, errors = 0, cyc = 0, strobes = 0;
  int mem_lat = 0, lat_cnt = 0;
  bit pend = 0;
  logic [31:0] mbase = 0, exp_addr = 0, maddr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  function automatic logic [31:0] desc_of(input logic [11:0] i);
    logic [11:0] hi; logic [19:0] mid; logic [1:0] typ;
    hi  = 12'(i * 5 + 9);
    mid = 20'(i * 20'h2c3d) ^ 20'h9a5;
    typ = i[1:0] ^ i[3:2];
    return {hi, mid[19:2], typ};
  endfunction

  always @(negedge clk) begin
    cyc++;
    mem_rvalid <= 0;
    mem_rdata  <= {cyc[15:0], cyc[15:0]} ^ 32'h5A5A_0002;
    if (pend) begin
      if (lat_cnt == 0) begin
        mem_rvalid <= 1;
        mem_rdata  <= desc_of(12'((maddr - mbase) >> 2));
        pend <= 0;
      end else lat_cnt <= lat_cnt - 1;
    end
    if (mem_rd) begin
      strobes++;
      chk(mem_addr == exp_addr, "R2 descriptor address", mem_addr, exp_addr);
      pend <= 1; lat_cnt <= mem_lat; maddr <= mem_addr;
    end
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic xlate(input logic [31:0] va, input bit en, input logic [31:0] base,
                       input int lat, input int hold, input bit scramble);
    int s0, n;
    logic [31:0] d, ep;
    bit efault;
    s0 = strobes; mem_lat = lat; mbase = base;
    exp_addr = base + {18'b0, va[31:20], 2'b00};
    @(negedge clk);
    req_valid = 1; req_vaddr = va; xlate_en = en; tbl_base = base;
    chk(req_ready == 1, "R7 ready when idle", {31'b0, req_ready}, 1);
    @(negedge clk);
    req_valid = 0;
    if (scramble) begin xlate_en = !en; tbl_base = ~base; req_vaddr = ~va; end
    n = 0;
    while (!rsp_valid && n < 40) begin
      chk(req_ready == 0, "R7 busy during walk", {31'b0, req_ready}, 0);
      @(negedge clk); n++;
    end
    d = desc_of(va[31:20]);
    efault = en && d[1:0] != 2'b10;
    ep = !en ? va : efault ? 32'h0 : {d[31:20], va[19:0]};
    chk(rsp_valid == 1, "R8 response arrives", {31'b0, rsp_valid}, 1);
    chk(rsp_paddr == ep, en ? (efault ? "R5 fault address" : "R3 section address") : "R6 bypass address", rsp_paddr, ep);
    chk(rsp_fault == efault, en ? "R5 fault flag" : "R6 no fault", {31'b0, rsp_fault}, {31'b0, efault});
    if (en && !efault)
      chk({rsp_apx, rsp_ap, rsp_domain, rsp_cache, rsp_buf} == {d[15], d[11:10], d[8:5], d[3], d[2]},
          "R4 attributes", {22'b0, rsp_apx, rsp_ap, rsp_domain, rsp_cache, rsp_buf},
          {22'b0, d[15], d[11:10], d[8:5], d[3], d[2]});
    else
      chk({rsp_apx, rsp_ap, rsp_domain, rsp_cache, rsp_buf} == 0, en ? "R5 attributes zero" : "R6 attributes zero",
          {22'b0, rsp_apx, rsp_ap, rsp_domain, rsp_cache, rsp_buf}, 0);
    chk(strobes - s0 == (en ? 1 : 0), en ? "R2 one strobe" : "R6 no read", strobes - s0, en ? 1 : 0);
    if (scramble) chk(rsp_paddr == ep, "R9 inputs sampled at accept", rsp_paddr, ep);
    for (int h = 0; h < hold; h++) begin
      req_valid = 1; req_vaddr = 32'hDEAD_0000;
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == ep && !req_ready, "R7 response held", rsp_paddr, ep);
    end
    rsp_ready = 1; req_valid = 0;
    @(negedge clk);
    rsp_ready = 0;
    chk(rsp_valid == 0, "R7 response taken", {31'b0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && mem_rd == 0, "R1 reset state",
        {29'b0, req_ready, rsp_valid, mem_rd}, 32'h4);
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] va;
      va = {12'(i), 20'(i * 20'h3b1 + 20'h1234)};
      xlate(va, 1, (i < 2048) ? 32'h5000_0000 : 32'h0123_4000, i % 4,
            (i % 5 == 0) ? 2 : 0, i % 7 == 0);
    end
    for (int i = 0; i < 64; i++)
      xlate({6'(i), 26'(i * 26'h13579b)}, 0, 32'h5000_0000, 0, (i % 3 == 0) ? 1 : 0, i % 2 == 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule